// File: doc/BRIEF.md
# Immediate-Compare Branch Resolver

This unit resolves conditional branches that test one source register against zero or against a small constant picked from a fixed table. The core gives it the raw instruction word, the PC of that instruction, a flag saying whether the instruction is 16 or 24 bits long, and the value already read from the source register. One cycle later it reports four things. It says whether the instruction is one of the branch forms it covers and whether the branch is taken. It gives the taken target and the fall-through PC. It also gives the PC that fetch should use next.

Four forms are covered, all as 24-bit words except the narrow one. The first compares the register with zero and carries a 12-bit signed offset. The second compares it with a signed table constant. The third compares it with an unsigned table constant. Both table forms carry an 8-bit signed offset. The fourth is a 16-bit form that only tests the register for zero or non-zero, with a short unsigned forward offset. Register read, fetch redirection and pipeline flush live outside this block.

Top module: `imm_branch_resolver`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier, and the asynchronous active-low reset clears it. The result outputs load only on a cycle where `in_valid` is high, and otherwise hold their value.
- R2: A 24-bit word with bits [3:0]=6 and bits [5:4]=1 is a zero-compare branch. Bits [7:6] pick the condition against zero: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal.
- R3: For the zero-compare form, the target is PC+4 plus the sign-extended 12-bit field in bits [23:12].
- R4: A 24-bit word with bits [3:0]=6 and bits [5:4]=2 compares the register with a signed constant using the R2 condition codes. Bits [15:12] index the constant table, in index order: -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256.
- R5: A 24-bit word with bits [3:0]=6, bits [5:4]=3 and bits [7:6] equal to 2 or 3 compares the register unsigned with a constant. Code 2 means less-than and code 3 means greater-or-equal. Bits [15:12] index the table, in index order: 32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256.
- R6: A word with bits [3:0]=6, bits [5:4]=3 and bits [7:6] equal to 0 or 1 is reported as not handled and not taken.
- R7: For both table-constant forms, the target is PC+4 plus the sign-extended 8-bit field in bits [23:16].
- R8: A 16-bit word (`in_narrow`=1) with bits [3:0]=12 and t=bits [7:4] where t[3]=1 is a narrow zero test. Here t[2]=1 means branch if non-zero and t[2]=0 means branch if zero. The target is PC+4+(r + 16·t[1:0]) with r=bits [15:12], and bits [23:16] are ignored.
- R9: The fall-through PC is PC+2 for 16-bit and PC+3 for 24-bit words. The next PC equals the target when taken and the fall-through PC otherwise.
- R10: Every other encoding is reported as not handled and not taken. This covers bits [3:0] other than 6 on a 24-bit word, bits [5:4]=0, a 16-bit word whose bits [3:0] are not 12 or whose t[3] is 0, and a 24-bit word with bits [3:0]=12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction present this cycle |
| in_narrow | input | 1 | 1: 16-bit instruction, 0: 24-bit instruction |
| in_insn | input | 24 | Instruction word (low 16 bits used for 16-bit form) |
| in_pc | input | 32 | Address of the instruction |
| in_rs | input | 32 | Value of the source register |
| out_valid | output | 1 | Result outputs refer to the last accepted instruction |
| out_handled | output | 1 | Instruction is one of the covered branch forms |
| out_taken | output | 1 | Branch condition holds |
| out_target | output | 32 | Taken destination |
| out_fallthru | output | 32 | Sequential successor address |
| out_next_pc | output | 32 | Target if taken, else fall-through |

## Verification
A wrong table entry or a wrong condition code shows up at `out_taken` and `out_next_pc` on the cycle after the instruction is accepted. It only shows when the register value sits at that constant's edge, which is why every index is driven one below, at, and one above its constant. A bad offset extension or a swapped PC increment shows in `out_target` or `out_fallthru` on that same cycle. A decode hole that lets a non-branch word through shows as `out_handled` rising where it must stay low.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam logic [3:0] OP0_WIDE_BR   = 4'd6;
  localparam logic [3:0] OP0_NARROW_BR = 4'd12;

  localparam logic [1:0] GRP_ZERO   = 2'd1;
  localparam logic [1:0] GRP_SCONST = 2'd2;
  localparam logic [1:0] GRP_UCONST = 2'd3;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_ZERO,
    FORM_SCONST,
    FORM_UCONST,
    FORM_NARROW
  } form_e;

  // Low four codes line up with the 2-bit condition field.
  typedef enum logic [2:0] {
    CMP_EQ    = 3'd0,
    CMP_NE    = 3'd1,
    CMP_LT    = 3'd2,
    CMP_GE    = 3'd3,
    CMP_LTU   = 3'd4,
    CMP_GEU   = 3'd5,
    CMP_NEVER = 3'd6
  } cond_e;

  function automatic logic [31:0] signed_const(input logic [3:0] idx);
    logic [31:0] v;
    case (idx)
      4'd0:    v = 32'hFFFF_FFFF;
      4'd9:    v = 32'd10;
      4'd10:   v = 32'd12;
      4'd11:   v = 32'd16;
      4'd12:   v = 32'd32;
      4'd13:   v = 32'd64;
      4'd14:   v = 32'd128;
      4'd15:   v = 32'd256;
      default: v = {28'd0, idx};
    endcase
    return v;
  endfunction

  function automatic logic [31:0] unsigned_const(input logic [3:0] idx);
    logic [31:0] v;
    case (idx)
      4'd0:    v = 32'd32768;
      4'd1:    v = 32'd65536;
      default: v = signed_const(idx);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 24
) (
  input  logic            narrow,
  input  logic [ILEN-1:0] insn,
  output form_e           form,
  output cond_e           cond,
  output logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] offset
);

  localparam int OFS12_LSB = ILEN - 12;
  localparam int OFS8_LSB  = ILEN - 8;

  logic [3:0]  op0;
  logic [1:0]  grp;
  logic [1:0]  mode;
  logic [3:0]  tfield;
  logic [3:0]  idx;
  logic [11:0] ofs12;
  logic [7:0]  ofs8;

  assign op0    = insn[3:0];
  assign grp    = insn[5:4];
  assign mode   = insn[7:6];
  assign tfield = insn[7:4];
  assign idx    = insn[15:12];
  assign ofs12  = insn[ILEN-1:OFS12_LSB];
  assign ofs8   = insn[ILEN-1:OFS8_LSB];

  always_comb begin
    form    = FORM_NONE;
    cond    = CMP_NEVER;
    operand = '0;
    offset  = '0;
    if (narrow) begin
      if (op0 == OP0_NARROW_BR && tfield[3]) begin
        form   = FORM_NARROW;
        cond   = tfield[2] ? CMP_NE : CMP_EQ;
        offset = XLEN'({tfield[1:0], idx});
      end
    end else if (op0 == OP0_WIDE_BR) begin
      case (grp)
        GRP_ZERO: begin
          form   = FORM_ZERO;
          cond   = cond_e'({1'b0, mode});
          offset = {{(XLEN-12){ofs12[11]}}, ofs12};
        end
        GRP_SCONST: begin
          form    = FORM_SCONST;
          cond    = cond_e'({1'b0, mode});
          operand = XLEN'(signed_const(idx));
          offset  = {{(XLEN-8){ofs8[7]}}, ofs8};
        end
        GRP_UCONST: begin
          if (mode[1]) begin
            form    = FORM_UCONST;
            cond    = mode[0] ? CMP_GEU : CMP_LTU;
            operand = XLEN'(unsigned_const(idx));
            offset  = {{(XLEN-8){ofs8[7]}}, ofs8};
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ibr_compare.sv
module ibr_compare
  import ibr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e           cond,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            hit
);

  logic eq, lt_s, lt_u;

  assign eq   = (lhs == rhs);
  assign lt_s = ($signed(lhs) < $signed(rhs));
  assign lt_u = (lhs < rhs);

  always_comb begin
    case (cond)
      CMP_EQ:  hit = eq;
      CMP_NE:  hit = !eq;
      CMP_LT:  hit = lt_s;
      CMP_GE:  hit = !lt_s;
      CMP_LTU: hit = lt_u;
      CMP_GEU: hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ibr_pc_calc.sv
module ibr_pc_calc #(
  parameter int XLEN     = 32,
  parameter int BR_BASE  = 4,
  parameter int LEN_WIDE = 3,
  parameter int LEN_NARW = 2
) (
  input  logic            narrow,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] fallthru
);

  localparam logic [XLEN-1:0] BASE_INC = XLEN'(BR_BASE);
  localparam logic [XLEN-1:0] WIDE_INC = XLEN'(LEN_WIDE);
  localparam logic [XLEN-1:0] NARW_INC = XLEN'(LEN_NARW);

  assign target   = pc + BASE_INC + offset;
  assign fallthru = pc + (narrow ? NARW_INC : WIDE_INC);

endmodule

// File: rtl/imm_branch_resolver.sv
module imm_branch_resolver
  import ibr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_narrow,
  input  logic [ILEN-1:0] in_insn,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_rs,
  output logic            out_valid,
  output logic            out_handled,
  output logic            out_taken,
  output logic [XLEN-1:0] out_target,
  output logic [XLEN-1:0] out_fallthru,
  output logic [XLEN-1:0] out_next_pc
);

  form_e           dec_form;
  cond_e           dec_cond;
  logic [XLEN-1:0] dec_operand;
  logic [XLEN-1:0] dec_offset;
  logic            cmp_hit;
  logic [XLEN-1:0] calc_target;
  logic [XLEN-1:0] calc_fallthru;
  logic            unused_src_sel;

  assign unused_src_sel = ^in_insn[11:8];

  ibr_decode #(.XLEN(XLEN), .ILEN(ILEN)) u_decode (
    .narrow  (in_narrow),
    .insn    (in_insn),
    .form    (dec_form),
    .cond    (dec_cond),
    .operand (dec_operand),
    .offset  (dec_offset)
  );

  ibr_compare #(.XLEN(XLEN)) u_compare (
    .cond (dec_cond),
    .lhs  (in_rs),
    .rhs  (dec_operand),
    .hit  (cmp_hit)
  );

  ibr_pc_calc #(.XLEN(XLEN)) u_pc_calc (
    .narrow   (in_narrow),
    .pc       (in_pc),
    .offset   (dec_offset),
    .target   (calc_target),
    .fallthru (calc_fallthru)
  );

  // Next-state logic
  logic            nxt_handled;
  logic            nxt_taken;
  logic [XLEN-1:0] nxt_next_pc;
  logic            res_en;

  assign res_en = in_valid;

  always_comb begin
    nxt_handled = (dec_form != FORM_NONE);
    nxt_taken   = nxt_handled && cmp_hit;
    nxt_next_pc = nxt_taken ? calc_target : calc_fallthru;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_handled  <= 1'b0;
      out_taken    <= 1'b0;
      out_target   <= '0;
      out_fallthru <= '0;
      out_next_pc  <= '0;
    end else if (res_en) begin
      out_handled  <= nxt_handled;
      out_taken    <= nxt_taken;
      out_target   <= calc_target;
      out_fallthru <= calc_fallthru;
      out_next_pc  <= nxt_next_pc;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_next_pc) && $stable(out_taken)));

  // R6
  taken_needs_handled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_taken |-> out_handled);

  // R9
  fallthru_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fallthru == $past(in_pc) + ($past(in_narrow) ? XLEN'(2) : XLEN'(3))));

  // R9
  next_pc_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_next_pc == (out_taken ? out_target : out_fallthru)));

endmodule

// File: tb/imm_branch_resolver_tb.sv
module imm_branch_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_narrow;
  logic [23:0] in_insn;
  logic [31:0] in_pc;
  logic [31:0] in_rs;
  logic        out_valid, out_handled, out_taken;
  logic [31:0] out_target, out_fallthru, out_next_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  imm_branch_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_narrow(in_narrow),
    .in_insn(in_insn), .in_pc(in_pc), .in_rs(in_rs),
    .out_valid(out_valid), .out_handled(out_handled), .out_taken(out_taken),
    .out_target(out_target), .out_fallthru(out_fallthru), .out_next_pc(out_next_pc)
  );

  function automatic int scon(input int i);
    case (i)
      0: return -1;
      9: return 10;
      10: return 12;
      11: return 16;
      12: return 32;
      13: return 64;
      14: return 128;
      15: return 256;
      default: return i;
    endcase
  endfunction

  function automatic int ucon(input int i);
    if (i == 0) return 32768;
    if (i == 1) return 65536;
    return scon(i);
  endfunction

  function automatic logic [31:0] pick_val(input int k);
    case (k % 6)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return 32'h0000_0005;
    endcase
  endfunction

  // returns {valid, handled, taken, target(masked), fallthru, next}
  function automatic logic [98:0] model(input logic nar, input logic [23:0] w,
                                        input logic [31:0] pc, input logic [31:0] rs);
    logic hd, tk;
    longint off, srs, urs, c;
    logic [31:0] tgt, fall;
    int op0, grp, md, t, r;
    hd = 0; tk = 0; off = 0;
    op0 = int'(w[3:0]); grp = int'(w[5:4]); md = int'(w[7:6]);
    t = int'(w[7:4]); r = int'(w[15:12]);
    srs = longint'($signed(rs)); urs = longint'(rs);
    fall = pc + (nar ? 32'd2 : 32'd3);
    if (nar) begin
      if (op0 == 12 && t >= 8) begin
        hd = 1;
        tk = ((t / 4) % 2 == 1) ? (urs != 0) : (urs == 0);
        off = r + 16 * (t % 4);
      end
    end else if (op0 == 6) begin
      if (grp == 1 || grp == 2) begin
        hd = 1;
        c = (grp == 1) ? 0 : longint'(scon(r));
        case (md)
          0: tk = (srs == c);
          1: tk = (srs != c);
          2: tk = (srs < c);
          default: tk = (srs >= c);
        endcase
        off = (grp == 1) ? longint'($signed(w[23:12])) : longint'($signed(w[23:16]));
      end else if (grp == 3 && md >= 2) begin
        hd = 1;
        c = longint'(ucon(r));
        tk = (md == 2) ? (urs < c) : (urs >= c);
        off = longint'($signed(w[23:16]));
      end
    end
    tgt = pc + 32'd4 + 32'(off);
    return {1'b1, hd, tk, (hd ? tgt : 32'd0), fall, (tk ? tgt : fall)};
  endfunction

  task automatic check_vec(input string tag, input logic [98:0] got, input logic [98:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drives at a falling edge, checks at the next falling edge.
  task automatic apply(input string tag, input logic nar, input logic [23:0] w,
                       input logic [31:0] pc, input logic [31:0] rs);
    logic [98:0] exp, got;
    in_valid = 1'b1; in_narrow = nar; in_insn = w; in_pc = pc; in_rs = rs;
    exp = model(nar, w, pc, rs);
    @(negedge clk);
    got = {out_valid, out_handled, out_taken, (out_handled ? out_target : 32'd0),
           out_fallthru, out_next_pc};
    check_vec(tag, got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1: watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [98:0] snap;
    logic [31:0] pc;
    rst_n = 1'b0; in_valid = 1'b0; in_narrow = 1'b0;
    in_insn = '0; in_pc = '0; in_rs = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_vec("R1 reset", {out_valid, out_handled, out_taken, out_next_pc}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 idle after reset", {98'd0, out_valid}, '0);

    pc = 32'h1000_0000;
    // R2 / R3 zero-compare sweep
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 6; k++)
        for (int o = 0; o < 4; o++) begin
          logic [11:0] ofs;
          case (o)
            0: ofs = 12'h7FF;
            1: ofs = 12'h800;
            2: ofs = 12'hFFF;
            default: ofs = 12'h123;
          endcase
          apply("R2 R3 zero", 1'b0, {ofs, 4'h3, 2'(m), 2'd1, 4'h6}, pc, pick_val(k + o));
          pc = pc + 32'h0000_0131;
        end

    // R4 / R5 / R6 / R7 table sweep with boundary values
    for (int g = 2; g < 4; g++)
      for (int i = 0; i < 16; i++)
        for (int m = 0; m < 4; m++)
          for (int d = -1; d <= 1; d++) begin
            logic [31:0] cv;
            logic [7:0]  ofs;
            cv  = (g == 2) ? 32'(scon(i)) : 32'(ucon(i));
            ofs = 8'((i * 37 + m * 11 + d * 97) & 255);
            apply((g == 2) ? "R4 R7 signed const" : ((m < 2) ? "R6 unsigned mode 0/1" : "R5 R7 unsigned const"),
                  1'b0, {ofs, 4'(i), 4'h9, 2'(m), 2'(g), 4'h6}, pc, cv + 32'(d));
            pc = pc + 32'h0000_0057;
          end

    // R8 narrow sweep, every t and r; high byte ignored
    for (int t = 0; t < 16; t++)
      for (int r = 0; r < 16; r++)
        for (int v = 0; v < 3; v++) begin
          logic [31:0] rs;
          rs = (v == 0) ? 32'd0 : ((v == 1) ? 32'd1 : 32'h8000_0000);
          apply((t >= 8) ? "R8 narrow" : "R10 narrow t3 clear", 1'b1,
                {8'hA5, 4'(r), 4'h2, 4'(t), 4'hC}, pc, rs);
          pc = pc + 32'h0000_0021;
        end

    // R9 wrap-around of PC arithmetic
    apply("R9 wrap wide", 1'b0, {12'h010, 4'h0, 2'd0, 2'd1, 4'h6}, 32'hFFFF_FFFE, 32'd0);
    apply("R9 wrap narrow", 1'b1, {8'h00, 4'hF, 4'h0, 4'hB, 4'hC}, 32'hFFFF_FFFF, 32'd7);

    // R10 unhandled encodings
    for (int op = 0; op < 16; op++) begin
      apply("R10 wide op0", 1'b0, {12'h004, 4'h0, 2'd0, 2'd1, 4'(op)}, pc, 32'd0);
      apply("R10 narrow op0", 1'b1, {8'h00, 4'h1, 4'h0, 4'h8, 4'(op)}, pc, 32'd0);
    end
    for (int m = 0; m < 4; m++)
      apply("R10 group 0", 1'b0, {12'h004, 4'h0, 2'(m), 2'd0, 4'h6}, pc, 32'd0);

    // R1 hold: in_valid low, inputs change, outputs must not move
    apply("R1 load", 1'b0, {12'h020, 4'h0, 2'd0, 2'd1, 4'h6}, 32'h0000_4000, 32'd0);
    snap = {out_valid, out_handled, out_taken, out_target, out_fallthru, out_next_pc};
    in_valid = 1'b0; in_narrow = 1'b1; in_insn = 24'h00_F8C; in_pc = 32'h1234_5678; in_rs = 32'd9;
    @(negedge clk);
    check_vec("R1 hold", {out_valid, out_handled, out_taken, out_target, out_fallthru, out_next_pc},
              {1'b0, snap[97:0]});
    @(negedge clk);
    check_vec("R1 hold second cycle", {out_valid, out_handled, out_taken, out_target, out_fallthru, out_next_pc},
              {1'b0, snap[97:0]});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule